// File: doc/BRIEF.md
# Power-Aware Watchdog Timer

This block is the watchdog of a small microcontroller core. A prescaler turns the oscillator clock into machine-cycle ticks. A counter advances on each tick once software has armed the watchdog. If software does not service the watchdog before the selected timeout, the block raises a reset pulse one tick wide. It then clears itself and stays off until software enables it again.

The timeout is chosen through a 3-bit select value S. The length is 2^(BASE_EXP+S) − 1 ticks. With the default parameters (12 clocks per tick, BASE_EXP of 14) this is 16383 ticks at S=0 and 2^21 − 1 ticks at S=7. Software enables the watchdog, and services it, by writing a two-byte key to the service register. The select value in force is the one captured at the last service.

The block is aware of the power modes:
- **Power-down:** counter and prescaler stop and keep their values.
- **Wake by the active-low, level-sensitive interrupt line:** counting stays held off until that line returns high. This keeps the watchdog quiet while the oscillator restarts.
- **Idle:** has no effect, so the watchdog keeps running.

Top module: `wdog_top`

## Requirements
- R1: After a hardware reset (`rst` high at a clock edge), `wdt_rst_o` is low, the select value is 0 and the watchdog is disabled. No pulse appears however long the block runs without a valid key.
- R2: Register writes use `wr_addr`:
  - A write with `wr_addr`=0 loads the select value S from `wr_data[2:0]`. Bits 7:3 are ignored.
  - A write with `wr_addr`=1 goes to the service register.
- R3: Two consecutive service-register writes of 0x1E then 0xE1 enable the watchdog and clear both the tick counter and the prescaler. A 0xE1 write that does not immediately follow a 0x1E service write is ignored.
- R4: After a valid key, `wdt_rst_o` rises PRESCALE·(2^(BASE_EXP+S) − 1) clock edges after the edge that took the 0xE1 write, provided no freeze occurs.
- R5: `wdt_rst_o` stays high for exactly one tick (PRESCALE clocks). The watchdog is then disabled with its counter at zero, and no further pulse comes without a new key.
- R6: A valid key written while the watchdog is counting restarts the full timeout from that write.
- R7: S is sampled only when a valid key is taken. Writing the select register while counting does not change the running timeout.
- R8: While `pdown_i` is high, counter and prescaler do not advance and keep their values. Each clock edge spent in power-down delays the pulse by one clock.
- R9: If power-down has been entered, counting stays stopped after `pdown_i` falls for as long as `wake_n_i` is low. It resumes on the first edge with `wake_n_i` high.
- R10: `idle_i` has no effect on counting or on the timeout.
- R11: A hardware reset during counting clears the count and disables the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = select register, 1 = service register |
| wr_data | input | 8 | Write data |
| idle_i | input | 1 | Core is in idle mode |
| pdown_i | input | 1 | Core is in power-down mode |
| wake_n_i | input | 1 | Active-low level wake interrupt line |
| wdt_rst_o | output | 1 | Watchdog reset pulse, one tick wide |

## Verification
On every cycle the assertions check four things:
- the count stays still during power-down and during the wake hold-off;
- a disabled watchdog holds a zero count;
- the count never reaches the active limit;
- a pulse only rises out of an enabled state, leaving it cleared and disabled.

Only the bench's scenarios can show the rest: the exact timeout length for each select value, the key sequence and its rejection of wrong patterns, the late sampling of the select value, the pulse width, and the fact that idle changes nothing. These need whole timeouts measured at the output port.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [7:0] KEY_ARM  = 8'h1E;
    localparam logic [7:0] KEY_FIRE = 8'hE1;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pmode_e;

    // power-down dominates idle
    function automatic pmode_e decode_mode(input logic idle, input logic pdown);
        if (pdown)     return PM_DOWN;
        else if (idle) return PM_IDLE;
        else           return PM_RUN;
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int PRESCALE = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;

    assign tick = run && (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)  pre_q <= '0;
        else if (run)    pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    output logic [SEL_W-1:0] sel_o,
    output logic             svc_o
);
    logic armed_q;

    assign svc_o = wr_en && wr_addr && armed_q && (wr_data == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            sel_o   <= '0;
        end else if (wr_en) begin
            if (!wr_addr) sel_o   <= wr_data[SEL_W-1:0];
            else          armed_q <= (wr_data == KEY_ARM);
        end
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 14,
    parameter int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             svc,
    input  logic [SEL_W-1:0] sel_live,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] lim,
    output logic             en_q,
    output logic             fire_q
);
    logic [SEL_W-1:0] sel_act_q;

    // wraps to all ones when the shift equals CNT_W
    assign lim = (CNT_W'(1) << (BASE_EXP + int'(sel_act_q))) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            en_q      <= 1'b0;
            fire_q    <= 1'b0;
            sel_act_q <= '0;
        end else if (svc) begin
            cnt_q     <= '0;
            en_q      <= 1'b1;
            sel_act_q <= sel_live;
        end else if (tick) begin
            fire_q <= 1'b0;
            if (en_q) begin
                if (cnt_q == lim - CNT_W'(1)) begin
                    fire_q <= 1'b1;
                    cnt_q  <= '0;
                    en_q   <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int PRESCALE = 12,
    parameter int BASE_EXP = 14,
    parameter int SEL_W    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       idle_i,
    input  logic       pdown_i,
    input  logic       wake_n_i,
    output logic       wdt_rst_o
);
    localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

    pmode_e           mode;
    logic             hold_q;
    logic             frozen;
    logic             tick;
    logic             svc;
    logic [SEL_W-1:0] sel_live;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             en_q;
    logic             fire_q;

    assign mode   = decode_mode(idle_i, pdown_i);
    assign frozen = (mode == PM_DOWN) || (hold_q && !wake_n_i);

    // hold-off armed by power-down, released once the wake line is high
    always_ff @(posedge clk) begin
        if (rst)                  hold_q <= 1'b0;
        else if (mode == PM_DOWN) hold_q <= 1'b1;
        else if (wake_n_i)        hold_q <= 1'b0;
    end

    wdog_regs #(.SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel_o   (sel_live),
        .svc_o   (svc)
    );

    wdog_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (!frozen),
        .clr  (svc),
        .tick (tick)
    );

    wdog_core #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .svc      (svc),
        .sel_live (sel_live),
        .cnt_q    (cnt_q),
        .lim      (lim),
        .en_q     (en_q),
        .fire_q   (fire_q)
    );

    assign wdt_rst_o = fire_q;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             pdown_i,
    input logic             wake_n_i,
    input logic             hold_q,
    input logic             en_q,
    input logic             fire_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] lim
);
    // R8
    a_r8_pdown_frozen: assert property (@(posedge clk) disable iff (rst)
        (pdown_i && !wr_en) |=> $stable(cnt_q));

    // R9
    a_r9_wake_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !wake_n_i && !wr_en) |=> $stable(cnt_q));

    // R1
    a_r1_off_count_zero: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (cnt_q == '0));

    // R4
    a_r4_below_limit: assert property (@(posedge clk) disable iff (rst)
        en_q |-> (cnt_q < lim));

    // R5
    a_r5_pulse_leaves_off: assert property (@(posedge clk) disable iff (rst)
        $rose(fire_q) |-> (!en_q && cnt_q == '0 && $past(en_q)));
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .pdown_i  (pdown_i),
    .wake_n_i (wake_n_i),
    .hold_q   (hold_q),
    .en_q     (en_q),
    .fire_q   (fire_q),
    .cnt_q    (cnt_q),
    .lim      (lim)
);

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
    localparam int P = 2;
    localparam int E = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       idle_i = 1'b0;
    logic       pdown_i = 1'b0;
    logic       wake_n_i = 1'b1;
    logic       wdt_rst_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    wdog_top #(.PRESCALE(P), .BASE_EXP(E), .SEL_W(3)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .idle_i(idle_i), .pdown_i(pdown_i), .wake_n_i(wake_n_i), .wdt_rst_o(wdt_rst_o)
    );

    function automatic int tmo(input int s);
        return P * ((1 << (E + s)) - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic service();
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
    endtask

    // edges from the last write until the pulse; optional power-down freeze
    task automatic measure(input int lim, input int f, input int h, output int n);
        n = 0;
        while (!wdt_rst_o && n < lim) begin
            if (f > 0 && n == 5)         begin pdown_i = 1'b1; wake_n_i = (h == 0); end
            if (f > 0 && n == 5 + f)     pdown_i = 1'b0;
            if (f > 0 && n == 5 + f + h) wake_n_i = 1'b1;
            @(posedge clk); n++; @(negedge clk);
        end
        pdown_i = 1'b0; wake_n_i = 1'b1;
    endtask

    task automatic width(output int w);
        w = 0;
        while (wdt_rst_o && w < 100) begin
            @(posedge clk); w++; @(negedge clk);
        end
    endtask

    task automatic quiet(input int len, input string req);
        int seen = 0;
        repeat (len) begin
            @(posedge clk); @(negedge clk);
            if (wdt_rst_o) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    typedef struct packed {
        logic [7:0] seldat;
        logic       idle;
        logic [7:0] f;
        logic [7:0] h;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{8'h00, 1'b0, 8'd0, 8'd0},
        '{8'h01, 1'b0, 8'd0, 8'd0},
        '{8'hF9, 1'b0, 8'd0, 8'd0},
        '{8'h03, 1'b1, 8'd0, 8'd0},
        '{8'h02, 1'b0, 8'd7, 8'd0},
        '{8'h00, 1'b0, 8'd4, 8'd6},
        '{8'h07, 1'b0, 8'd0, 8'd0},
        '{8'h05, 1'b1, 8'd3, 8'd3}
    };

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int w;
        int e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state and disabled after reset
        chk(wdt_rst_o == 1'b0, "R1 reset output", int'(wdt_rst_o), 0);
        quiet(200, "R1 no pulse while disabled");

        // vector walk: R2 R4 R5 R8 R9 R10
        for (int i = 0; i < 8; i++) begin
            wr(1'b0, VEC[i].seldat);
            idle_i = VEC[i].idle;
            service();
            e = tmo(int'(VEC[i].seldat[2:0])) + int'(VEC[i].f) + int'(VEC[i].h);
            measure(e + 50, int'(VEC[i].f), int'(VEC[i].h), n);
            chk(n == e, "R4/R2/R8/R9/R10 timeout", n, e);
            width(w);
            chk(w == P, "R5 pulse width", w, P);
            idle_i = 1'b0;
        end

        // R5: no second pulse after expiry
        wr(1'b0, 8'h00);
        quiet(100, "R5 disabled after pulse");

        // R3: wrong patterns ignored
        wr(1'b1, 8'h1E); wr(1'b1, 8'h55); wr(1'b1, 8'hE1);
        quiet(100, "R3 broken key ignored");
        wr(1'b1, 8'hE1);
        quiet(100, "R3 lone E1 ignored");
        service();
        measure(200, 0, 0, n);
        chk(n == tmo(0), "R3 valid key enables", n, tmo(0));
        width(w);

        // R6: re-service restarts
        service();
        repeat (20) @(posedge clk);
        @(negedge clk);
        service();
        measure(200, 0, 0, n);
        chk(n == tmo(0), "R6 restart on service", n, tmo(0));
        width(w);

        // R7: select change while counting has no effect until next service
        wr(1'b0, 8'h00);
        service();
        wr(1'b0, 8'h02);
        measure(400, 0, 0, n);
        chk(n + 2 == tmo(0), "R7 select latched at service", n + 2, tmo(0));
        width(w);
        service();
        measure(400, 0, 0, n);
        chk(n == tmo(2), "R7 new select after service", n, tmo(2));
        width(w);

        // R11: hardware reset mid-count
        wr(1'b0, 8'h00);
        service();
        repeat (10) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        quiet(200, "R11 reset disables");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule